// File: doc/BRIEF.md
# Serial Two-Wire Memory Slave

This block is the target side of a two-wire (I2C) link to a small byte-wide nonvolatile store. It watches the clock and data lines and finds START and STOP conditions. It accepts a device-select byte whose low address bits come from three strap pins. It then loads a two-byte word address and either stores a single data byte or streams bytes back to the master. Both bus lines are first passed through a synchronizer clocked by a fast system clock. The block drives data only through an open-drain pull-down enable.

A byte write does not reach the array until the master closes the transfer with STOP. At that point the block issues a one-cycle write strobe into the behavioural array and starts a programming timer. The timer runs for a parameter-set number of system clocks, and while it runs the slave neither acknowledges nor drives the bus. For reads, an internal pointer supplies the data and advances after every byte sent. The pointer wraps at the top of the array, so a read can either follow an address load or continue from wherever the pointer was left.

Top module: `ser_mem_slave`

## Requirements
- R1: A START (data falling while clock is high) aborts any transfer in progress and restarts byte reception at the device-select byte. A STOP (data rising while clock is high) returns the slave to idle.
- R2: The device-select byte is sent MSB first as 1,0,1,0, strap_i[2], strap_i[1], strap_i[0], then R/W (1 = read). The slave pulls data low during the ninth clock only when the upper seven bits match. On a mismatch it stays off the bus until the next START.
- R3: When the device-select byte has R/W = 0, the slave acknowledges the high word-address byte, the low word-address byte and the data byte. The pointer takes the low MEM_AW bits of {high, low}, and higher bits are ignored.
- R4: A STOP that follows an acknowledged data byte produces exactly one mem_we_o pulse, with mem_addr_o equal to the loaded address and mem_wdata_o equal to the data byte. A further byte sent before that STOP is not acknowledged, and the write still takes place.
- R5: A STOP or START that arrives before all eight data bits have been received cancels the write: no strobe occurs and the array is unchanged.
- R6: For PROG_CYCLES system clocks after the strobe, the slave does not acknowledge any device-select byte, including a matching one, and never pulls data low.
- R7: In a read, the slave drives eight bits MSB first and releases data for the ninth clock. The pointer then advances by one and wraps from the last location to 0.
- R8: If the master acknowledges (data low on the ninth clock), the next byte follows. If it does not, the slave leaves data released through any further clocks until a STOP or START.
- R9: A read with no preceding address load starts at the current pointer. After a byte write the pointer still holds the written address.
- R10: sda_pull_o changes only while the synchronized clock is low.
- R11: After reset, sda_pull_o and mem_we_o are 0 and mem_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line as seen on the wire, raw |
| strap_i | input | 3 | Strap pins that set the low device-select bits |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| mem_addr_o | output | MEM_AW | Address pointer into the array |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_we_o | output | 1 | One-cycle write strobe into the array |
| mem_rdata_o | output | 8 | Array contents at the pointer |

## Verification
The bench writes every location of a 16-byte configuration with garbage in the unused address bits. A design that used the wrong address bits would strobe or read back the wrong byte. It also starts a sequential read near the top of the array to show the wraparound; a pointer without wrap would return stale high bytes. Transfers cut off by STOP or by a repeated START partway through the data byte must leave the array untouched; a design that armed the write too early would corrupt that location. A device-select sent while the timer runs, a select with a wrong strap, extra clocks after a master NACK, and the pointer left by a write all check that the slave stays silent or resumes where the requirements say. A design that answered during programming or kept driving after a NACK would show pull-downs where none may appear.

// File: rtl/sms_pkg.sv
package sms_pkg;
   localparam logic [3:0] DEV_PREFIX = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_HOLD
   } sms_state_t;

   typedef enum logic [1:0] {
      ROLE_DEV,
      ROLE_AHI,
      ROLE_ALO,
      ROLE_DATA
   } sms_role_t;
endpackage

// File: rtl/sms_bus_sync.sv
module sms_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sms_bus_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_q[0] <= 1'b1;
                  sda_q[0] <= 1'b1;
               end else begin
                  scl_q[0] <= scl_i;
                  sda_q[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_q[s] <= 1'b1;
                  sda_q[s] <= 1'b1;
               end else begin
                  scl_q[s] <= scl_q[s-1];
                  sda_q[s] <= sda_q[s-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_o;
         sda_d <= sda_o;
      end
   end

   assign scl_o      = scl_q[STAGES-1];
   assign sda_o      = sda_q[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/sms_prog_timer.sv
module sms_prog_timer #(
   parameter int CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("sms_prog_timer: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start_i)
         cnt <= CW'(CYCLES);
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign busy_o = (cnt != '0);

   // R6
   busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> (cnt == $past(cnt) - CW'(1)));

   // R6
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
endmodule

// File: rtl/sms_mem_array.sv
module sms_mem_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   generate
      if (AW < 1 || AW > 16) begin : g_bad_aw
         $error("sms_mem_array: AW out of range 1..16");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i)
         mem[addr_i] <= wdata_i;
   end

   assign rdata_o = mem[addr_i];
endmodule

// File: rtl/ser_mem_slave.sv
module ser_mem_slave
   import sms_pkg::*;
#(
   parameter int MEM_AW      = 11,
   parameter int PROG_CYCLES = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        strap_i,
   output logic              sda_pull_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   output logic              mem_we_o,
   output logic [7:0]        mem_rdata_o
);
   localparam int BITS = 8;
   localparam logic [3:0] LAST_RX = 4'(BITS);
   localparam logic [3:0] LAST_TX = 4'(BITS - 1);

   generate
      if (MEM_AW > 16) begin : g_bad_aw
         $error("ser_mem_slave: MEM_AW cannot exceed the 16-bit word address");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic busy;

   sms_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (bus_start),
      .stop_o     (bus_stop)
   );

   sms_state_t        st;
   sms_role_t         role;
   logic [7:0]        shreg;
   logic [3:0]        bitcnt;
   logic              rw;
   logic [7:0]        ahi;
   logic [7:0]        wdata;
   logic              wr_pend;
   logic              mack;
   logic [MEM_AW-1:0] ptr;
   logic              pull;
   logic              we;
   logic [7:0]        rdata;
   logic              dev_match;

   assign dev_match = (shreg[7:1] == {DEV_PREFIX, strap_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         role    <= ROLE_DEV;
         shreg   <= '0;
         bitcnt  <= '0;
         rw      <= 1'b0;
         ahi     <= '0;
         wdata   <= '0;
         wr_pend <= 1'b0;
         mack    <= 1'b0;
         ptr     <= '0;
         pull    <= 1'b0;
         we      <= 1'b0;
      end else begin
         we <= 1'b0;
         if (busy) begin
            st      <= ST_IDLE;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
         end else if (bus_stop) begin
            st      <= ST_IDLE;
            pull    <= 1'b0;
            we      <= wr_pend;
            wr_pend <= 1'b0;
         end else if (bus_start) begin
            st      <= ST_RX;
            role    <= ROLE_DEV;
            bitcnt  <= '0;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise && bitcnt < LAST_RX) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == LAST_RX) begin
                     unique case (role)
                        ROLE_DEV: begin
                           if (dev_match) begin
                              rw   <= shreg[0];
                              pull <= 1'b1;
                              st   <= ST_RX_ACK;
                           end else begin
                              st <= ST_HOLD;
                           end
                        end
                        ROLE_AHI: begin
                           ahi  <= shreg;
                           pull <= 1'b1;
                           st   <= ST_RX_ACK;
                        end
                        ROLE_ALO: begin
                           ptr  <= MEM_AW'({ahi, shreg});
                           pull <= 1'b1;
                           st   <= ST_RX_ACK;
                        end
                        ROLE_DATA: begin
                           wdata   <= shreg;
                           wr_pend <= 1'b1;
                           pull    <= 1'b1;
                           st      <= ST_RX_ACK;
                        end
                        default: st <= ST_HOLD;
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     pull   <= 1'b0;
                     bitcnt <= '0;
                     unique case (role)
                        ROLE_DEV: begin
                           if (rw) begin
                              shreg <= rdata;
                              pull  <= ~rdata[7];
                              st    <= ST_TX;
                           end else begin
                              role <= ROLE_AHI;
                              st   <= ST_RX;
                           end
                        end
                        ROLE_AHI: begin
                           role <= ROLE_ALO;
                           st   <= ST_RX;
                        end
                        ROLE_ALO: begin
                           role <= ROLE_DATA;
                           st   <= ST_RX;
                        end
                        default: st <= ST_HOLD;
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt < LAST_TX) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        pull   <= ~shreg[6];
                        bitcnt <= bitcnt + 4'd1;
                     end else begin
                        pull <= 1'b0;
                        ptr  <= ptr + MEM_AW'(1);
                        st   <= ST_TX_ACK;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (mack) begin
                        shreg <= rdata;
                        pull  <= ~rdata[7];
                        st    <= ST_TX;
                     end else begin
                        st <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   sms_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (we),
      .busy_o  (busy)
   );

   sms_mem_array #(.AW(MEM_AW), .DW(8)) i_mem (
      .clk     (clk),
      .we_i    (we),
      .addr_i  (ptr),
      .wdata_i (wdata),
      .rdata_o (rdata)
   );

   assign sda_pull_o  = pull;
   assign mem_addr_o  = ptr;
   assign mem_wdata_o = wdata;
   assign mem_we_o    = we;
   assign mem_rdata_o = rdata;

   // R10
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

   // R6
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_pull_o);

   // R4
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> (!mem_we_o && busy));

   // R2
   ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull_o) && $past(st) == ST_RX && $past(role) == ROLE_DEV)
         |-> ($past(shreg[7:1]) == {DEV_PREFIX, $past(strap_i)}));

   // R1
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && !busy) |=> (st == ST_RX && role == ROLE_DEV && bitcnt == 4'd0 && !sda_pull_o));
endmodule

// File: tb/test_ser_mem_slave.sv
module test_ser_mem_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 4;
   localparam int H = 8;
   localparam int TB_AW = 4;
   localparam int TB_PROG = 300;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic pull, we;
   logic [TB_AW-1:0] maddr;
   logic [7:0] mwdata, mrdata;
   wire sda_bus = m_sda & ~pull;

   int checks = 0;
   int errs = 0;
   int we_cnt = 0;
   logic [TB_AW-1:0] we_addr = '0;
   logic [7:0] we_data = '0;
   logic mon_pull = 1'b0;
   logic [7:0] exp_mem [1 << TB_AW];

   always #(CLK_PERIOD / 2) clk = ~clk;

   ser_mem_slave #(.MEM_AW(TB_AW), .PROG_CYCLES(TB_PROG), .SYNC_STAGES(2)) i_ser_mem_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .strap_i     (STRAP),
      .sda_pull_o  (pull),
      .mem_addr_o  (maddr),
      .mem_wdata_o (mwdata),
      .mem_we_o    (we),
      .mem_rdata_o (mrdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R10 monitor and write-strobe capture, sampled after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (pull !== mon_pull) begin
            checks++;
            if (scl) begin
               errs++;
               $display("FAIL R10 pull changed with clock high actual=%0b expected=%0b", pull, mon_pull);
            end
         end
         if (we) begin
            we_cnt++;
            we_addr = maddr;
            we_data = mwdata;
         end
      end
      mon_pull = pull;
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      if (!scl) begin
         wq(Q); m_sda = 1'b1; wq(Q); scl = 1'b1; wq(H);
      end else begin
         m_sda = 1'b1; wq(H);
      end
      m_sda = 1'b0; wq(H); scl = 1'b0;
   endtask

   task automatic do_stop();
      wq(Q); m_sda = 1'b0; wq(Q); scl = 1'b1; wq(H); m_sda = 1'b1; wq(H);
   endtask

   task automatic put_bit(input logic b);
      wq(Q); m_sda = b; wq(Q); scl = 1'b1; wq(H); scl = 1'b0;
   endtask

   task automatic get_bit(input logic drive, output logic b);
      wq(Q); m_sda = drive; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic ackm, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) get_bit(1'b1, d[i]);
      get_bit(~ackm, s);
   endtask

   task automatic write_one(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d,
                            output int acks);
      logic a;
      acks = 0;
      do_start();
      send_byte(DEV_W, a); acks += int'(a);
      send_byte(hi, a);    acks += int'(a);
      send_byte(lo, a);    acks += int'(a);
      send_byte(d, a);     acks += int'(a);
   endtask

   task automatic run();
      int acks, cnt0;
      logic a;
      logic [7:0] d;

      // R11 reset state
      wq(3);
      chk("R11 pull after reset", pull, 0);
      chk("R11 strobe after reset", we, 0);
      chk("R11 pointer after reset", maddr, 0);
      rst_n = 1'b1;
      wq(5);

      // R3 R4 R6: sweep all locations with garbage in the unused address bits
      for (int i = 0; i < (1 << TB_AW); i++) begin
         logic [7:0] v;
         v = 8'((i * 37 + 5) & 8'hFF);
         exp_mem[i] = v;
         cnt0 = we_cnt;
         write_one(8'h5A ^ 8'(i), {4'(i * 3 + 1), 4'(i)}, v, acks);
         chk("R3 acks on write bytes", acks, 4);
         do_stop();
         wq(2);
         chk("R4 single strobe", we_cnt - cnt0, 1);
         chk("R4 strobe address", we_addr, i);
         chk("R4 strobe data", we_data, v);
         if (i < 2) begin
            // R6 matching select during programming gets no ack
            do_start();
            send_byte(DEV_W, a);
            chk("R6 no ack while busy", a, 0);
            send_byte(8'h00, a);
            chk("R6 no ack on later byte while busy", a, 0);
            do_stop();
         end
         wq(TB_PROG + 20);
      end

      // R7 R8: sequential read across the wrap
      do_start();
      send_byte(DEV_W, a); chk("R3 select ack", a, 1);
      send_byte(8'hFF, a); chk("R3 high address ack", a, 1);
      send_byte(8'hFE, a); chk("R3 low address ack", a, 1);
      do_start();
      send_byte(DEV_R, a); chk("R2 read select ack", a, 1);
      for (int k = 0; k < 5; k++) begin
         recv_byte(k < 4, d);
         chk("R7 sequential read with wrap", d, exp_mem[(14 + k) % (1 << TB_AW)]);
      end
      // R8 after NACK, extra clocks see no drive
      recv_byte(1'b0, d);
      chk("R8 released after master NACK", d, 8'hFF);
      do_stop();

      // R9 current-address read continues at pointer (3)
      do_start();
      send_byte(DEV_R, a); chk("R9 current read ack", a, 1);
      recv_byte(1'b0, d);
      chk("R9 current read data", d, exp_mem[3]);
      do_stop();

      // R2 wrong strap and wrong prefix are ignored
      cnt0 = we_cnt;
      do_start();
      send_byte({4'b1010, STRAP ^ 3'b010, 1'b0}, a);
      chk("R2 no ack on wrong strap", a, 0);
      send_byte(8'h00, a); chk("R2 ignored byte", a, 0);
      send_byte(8'h02, a); chk("R2 ignored byte", a, 0);
      send_byte(8'h99, a); chk("R2 ignored byte", a, 0);
      do_stop();
      do_start();
      send_byte({4'b1011, STRAP, 1'b0}, a);
      chk("R2 no ack on wrong prefix", a, 0);
      do_stop();
      wq(4);
      chk("R2 no strobe from foreign select", we_cnt - cnt0, 0);

      // R5 cancel by STOP inside the data byte
      do_start();
      send_byte(DEV_W, a);
      send_byte(8'h00, a);
      send_byte(8'h03, a);
      for (int b = 0; b < 4; b++) put_bit(1'b0);
      do_stop();
      wq(4);
      chk("R5 no strobe after early STOP", we_cnt - cnt0, 0);
      do_start();
      send_byte(DEV_R, a);
      recv_byte(1'b0, d);
      chk("R5 location kept after early STOP", d, exp_mem[3]);
      do_stop();

      // R5 R1 cancel by repeated START inside the data byte
      do_start();
      send_byte(DEV_W, a);
      send_byte(8'h00, a);
      send_byte(8'h05, a);
      for (int b = 0; b < 5; b++) put_bit(1'b1);
      do_start();
      send_byte(DEV_R, a);
      chk("R1 select after repeated START acked", a, 1);
      recv_byte(1'b0, d);
      chk("R5 location kept after repeated START", d, exp_mem[5]);
      do_stop();
      wq(4);
      chk("R5 no strobe after repeated START", we_cnt - cnt0, 0);

      // R4 extra byte before STOP gets no ack; R9 pointer keeps written address
      write_one(8'h00, 8'h09, 8'hC3, acks);
      chk("R3 acks on write bytes", acks, 4);
      send_byte(8'h77, a);
      chk("R4 extra byte not acked", a, 0);
      do_stop();
      wq(2);
      chk("R4 strobe despite extra byte", we_cnt - cnt0, 1);
      chk("R4 strobe data", we_data, 8'hC3);
      exp_mem[9] = 8'hC3;
      wq(TB_PROG + 20);
      do_start();
      send_byte(DEV_R, a);
      recv_byte(1'b1, d);
      chk("R9 pointer at written address", d, 8'hC3);
      recv_byte(1'b0, d);
      chk("R7 pointer advanced after read", d, exp_mem[10]);
      do_stop();
   endtask

   initial begin
      fork
         run();
         begin
            repeat (150000) @(posedge clk);
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule